// File: doc/BRIEF.md
# Five-Port Packet-Allocated Stream Crossbar

This block connects five streaming input ports to five streaming output ports through one shared path. The ports are numbered by mesh direction: terminal is 0, west 1, east 2, north 3 and south 4. An external arbiter picks which input owns the switch and presents that choice on a 3-bit allocation input. It keeps the choice fixed from the first word of a packet until the word that carries `last`. Only the owning input is connected. All other inputs see `ready` held low.

Each input word carries a 4-bit destination field. Bits [2:0] name the output port and bit [3] is a virtual-channel flag. The output port and the flag are latched when a packet's first word is accepted, and they steer every later word of that packet. The block does no buffering: valid, data and last pass straight through to the chosen output, and that output's `ready` passes straight back to the owning input. The four neighbour outputs carry the virtual-channel flag. The terminal output has no flag, so any flag sent to it is lost. A packet whose port index is 5, 6 or 7 is accepted and thrown away.

Top module: `pkt_xbar5`

## Requirements
- R1: After reset, the block is between packets and no output asserts valid while no input is valid.
- R2: On the first word of a packet, only the output whose index equals destination bits [2:0] (values 0..4) asserts valid. That output carries the word's data and `last` unchanged.
- R3: Neighbour output p (1..4) presents, on `out_vc[p-1]`, destination bit [3] of the packet's first word for every word of the packet.
- R4: The allocated input's `ready` equals the `ready` of the output that its packet is routed to.
- R5: Every input other than the allocated one sees `ready` low, and its valid, data and destination have no effect on any output.
- R6: The output port and flag latched on the first accepted word are used for every later word of the packet, whatever those words carry in their destination field.
- R7: A packet whose port index is 5..7 raises no output valid. The allocated input's `ready` is held high until the packet's `last` word is taken, so the whole packet is dropped.
- R8: An allocation value of 5..7 connects no input: every input `ready` and every output valid stays low.
- R9: Once the `last` word is accepted, the next accepted word starts a new packet and is routed by its own destination field.
- R10: While the chosen output holds `ready` low, no word is taken, the word stays on that output, and the packet keeps its route.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc | input | 3 | Index of the input that owns the switch; held for a whole packet |
| in_data | input | 5*DATA_W | Input data, port i in slice i |
| in_dest | input | 5*4 | Input destination: [3] virtual channel, [2:0] output port |
| in_last | input | 5 | Input end-of-packet flags |
| in_valid | input | 5 | Input valid flags |
| in_ready | output | 5 | Input ready flags |
| out_data | output | 5*DATA_W | Output data, port p in slice p |
| out_vc | output | 4 | Virtual-channel flag of outputs 1..4 (bit p-1 for port p) |
| out_last | output | 5 | Output end-of-packet flags |
| out_valid | output | 5 | Output valid flags |
| out_ready | input | 5 | Output ready flags |

## Verification
Two functions can land in the same cycle. One is latching a new route on a packet's first word. The other is the back-pressure hold on that same word, when the chosen output is not ready and the neighbouring outputs are. To provoke this, the bench sweeps every allocation, port index and flag value, and stalls some first words with exactly the routed output's `ready` low. It checks that nothing is taken during the stall and that the later body words still follow the latched route, even though their destination fields point somewhere else. Unallocated inputs stay valid the whole time, with different destinations, so that any leak from them would show up on an output.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int XB_NPORT  = 5;
    localparam int XB_PORT_W = $clog2(XB_NPORT);
    localparam int XB_DEST_W = XB_PORT_W + 1;

    typedef logic [XB_PORT_W-1:0] port_idx_t;

    // port indices fixed by mesh direction
    localparam port_idx_t PORT_TERM  = 3'd0;
    localparam port_idx_t PORT_WEST  = 3'd1;
    localparam port_idx_t PORT_EAST  = 3'd2;
    localparam port_idx_t PORT_NORTH = 3'd3;
    localparam port_idx_t PORT_SOUTH = 3'd4;

    // context of the packet in flight
    typedef struct packed {
        logic      busy;
        port_idx_t port;
        logic      vc;
    } pkt_ctx_t;
endpackage

// File: rtl/xbar_in_select.sv
module xbar_in_select
    import xbar_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  port_idx_t                     alloc,
    input  logic [XB_NPORT*DATA_W-1:0]    in_data,
    input  logic [XB_NPORT*XB_DEST_W-1:0] in_dest,
    input  logic [XB_NPORT-1:0]           in_last,
    input  logic [XB_NPORT-1:0]           in_valid,
    output logic [XB_NPORT-1:0]           in_ready,
    input  logic                          sel_ready,
    output logic                          sel_valid,
    output logic [DATA_W-1:0]             sel_data,
    output logic [XB_DEST_W-1:0]          sel_dest,
    output logic                          sel_last
);
    always_comb begin
        sel_valid = 1'b0;
        sel_data  = '0;
        sel_dest  = '0;
        sel_last  = 1'b0;
        for (int i = 0; i < XB_NPORT; i++) begin
            if (alloc == port_idx_t'(i)) begin
                sel_valid = in_valid[i];
                sel_data  = in_data[i*DATA_W +: DATA_W];
                sel_dest  = in_dest[i*XB_DEST_W +: XB_DEST_W];
                sel_last  = in_last[i];
            end
        end
    end

    for (genvar g = 0; g < XB_NPORT; g++) begin : g_rdy
        assign in_ready[g] = (alloc == port_idx_t'(g)) && sel_ready;
    end

    // only the owner may ever be ready
    p_ready_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));
endmodule

// File: rtl/xbar_head_track.sv
module xbar_head_track
    import xbar_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire,
    input  logic      last,
    input  port_idx_t head_port,
    input  logic      head_vc,
    output port_idx_t eff_port,
    output logic      eff_vc,
    output logic      busy
);
    pkt_ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (fire) begin
            if (!ctx_q.busy) begin
                ctx_d.port = head_port;
                ctx_d.vc   = head_vc;
            end
            ctx_d.busy = !last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign eff_port = ctx_q.busy ? ctx_q.port : head_port;
    assign eff_vc   = ctx_q.busy ? ctx_q.vc   : head_vc;
    assign busy     = ctx_q.busy;

    // a taken non-final word keeps the route for the next word
    p_route_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last) |=> (busy && eff_port == $past(eff_port) && eff_vc == $past(eff_vc)));
    // a taken final word ends the packet
    p_packet_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last) |=> !busy);
endmodule

// File: rtl/xbar_out_steer.sv
module xbar_out_steer
    import xbar_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_valid,
    input  logic [DATA_W-1:0]          sel_data,
    input  logic                       sel_last,
    input  port_idx_t                  eff_port,
    input  logic                       eff_vc,
    output logic                       sel_ready,
    output logic [XB_NPORT*DATA_W-1:0] out_data,
    output logic [XB_NPORT-2:0]        out_vc,
    output logic [XB_NPORT-1:0]        out_last,
    output logic [XB_NPORT-1:0]        out_valid,
    input  logic [XB_NPORT-1:0]        out_ready
);
    logic port_ok;
    assign port_ok = (eff_port < port_idx_t'(XB_NPORT));

    for (genvar p = 0; p < XB_NPORT; p++) begin : g_out
        assign out_valid[p]                 = sel_valid && (eff_port == port_idx_t'(p));
        assign out_data[p*DATA_W +: DATA_W] = sel_data;
        assign out_last[p]                  = sel_last;
        if (p > 0) begin : g_vc
            assign out_vc[p-1] = eff_vc;
        end
    end

    always_comb begin
        sel_ready = 1'b1; // unknown port: sink the word
        for (int p = 0; p < XB_NPORT; p++) begin
            if (eff_port == port_idx_t'(p)) sel_ready = out_ready[p];
        end
    end

    p_one_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));
    p_drop_sink_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !port_ok) |-> (sel_ready && out_valid == '0));
endmodule

// File: rtl/pkt_xbar5.sv
module pkt_xbar5
    import xbar_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [XB_PORT_W-1:0]          alloc,
    input  logic [XB_NPORT*DATA_W-1:0]    in_data,
    input  logic [XB_NPORT*XB_DEST_W-1:0] in_dest,
    input  logic [XB_NPORT-1:0]           in_last,
    input  logic [XB_NPORT-1:0]           in_valid,
    output logic [XB_NPORT-1:0]           in_ready,
    output logic [XB_NPORT*DATA_W-1:0]    out_data,
    output logic [XB_NPORT-2:0]           out_vc,
    output logic [XB_NPORT-1:0]           out_last,
    output logic [XB_NPORT-1:0]           out_valid,
    input  logic [XB_NPORT-1:0]           out_ready
);
    logic                 sel_valid, sel_ready, sel_last, fire, busy, eff_vc;
    logic [DATA_W-1:0]    sel_data;
    logic [XB_DEST_W-1:0] sel_dest;
    port_idx_t            eff_port;

    assign fire = sel_valid && sel_ready;

    xbar_in_select #(.DATA_W(DATA_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .alloc(alloc),
        .in_data(in_data), .in_dest(in_dest), .in_last(in_last),
        .in_valid(in_valid), .in_ready(in_ready), .sel_ready(sel_ready),
        .sel_valid(sel_valid), .sel_data(sel_data), .sel_dest(sel_dest),
        .sel_last(sel_last)
    );

    xbar_head_track u_trk (
        .clk(clk), .rst_n(rst_n), .fire(fire), .last(sel_last),
        .head_port(sel_dest[XB_PORT_W-1:0]), .head_vc(sel_dest[XB_DEST_W-1]),
        .eff_port(eff_port), .eff_vc(eff_vc), .busy(busy)
    );

    xbar_out_steer #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_data(sel_data),
        .sel_last(sel_last), .eff_port(eff_port), .eff_vc(eff_vc),
        .sel_ready(sel_ready), .out_data(out_data), .out_vc(out_vc),
        .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready)
    );

    // any output activity must come from the allocated input
    p_valid_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> (alloc < XB_PORT_W'(XB_NPORT) && in_valid[alloc]));
    p_no_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc >= XB_PORT_W'(XB_NPORT)) |-> (in_ready == '0 && out_valid == '0));
    // arbiter contract: ownership held through a packet
    p_alloc_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(alloc));
    p_ready_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc < XB_PORT_W'(XB_NPORT) && eff_port < XB_PORT_W'(XB_NPORT))
            |-> (in_ready[alloc] == out_ready[eff_port]));
endmodule

// File: tb/tb_pkt_xbar5.sv
module tb_pkt_xbar5;
    localparam int NP = 5;
    localparam int DW = 32;
    localparam int TW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      alloc = '0;
    logic [NP*DW-1:0] in_data = '0;
    logic [NP*TW-1:0] in_dest = '0;
    logic [NP-1:0]   in_last = '0, in_valid = '0, in_ready;
    logic [NP*DW-1:0] out_data;
    logic [NP-2:0]   out_vc;
    logic [NP-1:0]   out_last, out_valid;
    logic [NP-1:0]   out_ready = '0;

    int n_chk = 0, n_bad = 0, n_pkt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pkt_xbar5 #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .alloc(alloc), .in_data(in_data),
        .in_dest(in_dest), .in_last(in_last), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_vc(out_vc),
        .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wdata(int a, int d, int v, int w);
        return 32'hA000_0000 | (a << 12) | (d << 8) | (v << 4) | w;
    endfunction

    // drive one word of the allocated packet; other inputs carry noise
    task automatic drive(int a, int d, int v, int w, int len, logic [NP-1:0] ordy);
        for (int i = 0; i < NP; i++) begin
            in_valid[i]           = 1'b1;
            in_last[i]            = 1'b1;
            in_data[i*DW +: DW]   = 32'h5000_0000 | i;
            in_dest[i*TW +: TW]   = TW'(8 | ((i + 2) % 8));
        end
        alloc = 3'(a);
        if (a < NP) begin
            in_data[a*DW +: DW] = wdata(a, d, v, w);
            in_last[a]          = (w == len - 1);
            // body words carry a misleading destination
            if (w == 0) in_dest[a*TW +: TW] = TW'((v << 3) | d);
            else        in_dest[a*TW +: TW] = TW'(((1 - v) << 3) | ((d + 3) % 8));
        end
        out_ready = ordy;
    endtask

    initial begin
        #(64'd8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == '0, "R1", "in_ready after reset", in_ready, 0);
        @(negedge clk);

        for (int a = 0; a < 8; a++) begin
            for (int d = 0; d < 8; d++) begin
                for (int v = 0; v < 2; v++) begin
                    int len;
                    len = 1 + ((d + v + a) % 3);
                    if (a >= NP) begin
                        drive(a, d, v, 0, len, 5'h1f);
                        #2;
                        chk(in_ready == '0, "R8", "in_ready idle alloc", in_ready, 0);
                        chk(out_valid == '0, "R8", "out_valid idle alloc", out_valid, 0);
                        @(negedge clk);
                        continue;
                    end
                    for (int w = 0; w < len; w++) begin
                        logic [NP-1:0] ev;
                        ev = (d < NP) ? NP'(1 << d) : '0;
                        if (w == 0 && d < NP && ((a + d + v) % 2 == 0)) begin
                            drive(a, d, v, w, len, ~NP'(1 << d));
                            #2;
                            chk(in_ready == '0, "R10", "in_ready stalled", in_ready, 0);
                            chk(out_valid == ev, "R10", "out_valid stalled", out_valid, ev);
                            @(negedge clk);
                        end
                        drive(a, d, v, w, len, 5'h1f);
                        #2;
                        if (d >= NP)
                            chk(out_valid == '0, "R7", "out_valid dropped", out_valid, 0);
                        else if (w > 0)
                            chk(out_valid == ev, "R6", "out_valid body", out_valid, ev);
                        else if (n_pkt > 0)
                            chk(out_valid == ev, "R9", "out_valid head", out_valid, ev);
                        else
                            chk(out_valid == ev, "R2", "out_valid head", out_valid, ev);
                        chk(in_ready[a] == 1'b1, (d >= NP) ? "R7" : "R4",
                            "owner ready", in_ready[a], 1);
                        chk((in_ready & ~NP'(1 << a)) == '0, "R5", "others ready",
                            in_ready, NP'(1 << a));
                        if (d < NP) begin
                            chk(out_data[d*DW +: DW] == wdata(a, d, v, w), "R2", "out_data",
                                out_data[d*DW +: DW], wdata(a, d, v, w));
                            chk(out_last[d] == (w == len - 1), "R2", "out_last",
                                out_last[d], (w == len - 1));
                            if (d > 0)
                                chk(out_vc[d-1] == 1'(v), "R3", "out_vc", out_vc[d-1], v);
                        end
                        @(negedge clk);
                    end
                    n_pkt++;
                end
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule